// File: doc/BRIEF.md
# Compressed Hierarchy Traversal Thread Controller

This block walks a compressed binary bounding-volume hierarchy for several ray threads at once. Each node-pair record is 64 bits wide. It holds the boxes of both children, which are rebuilt from the parent box and a per-plane ownership mask, and a short pointer for each child. The pointer is an offset from the thread's current cluster base. For every thread the block keeps the current node, the latest decoded children, a four-entry stack, and the root so that it can restart.

A thread is started with a cluster base and a root box. The block issues a node-pair fetch, and when the record returns it forwards the two rebuilt child boxes to an external box tester in the same cycle. From the returned hit and near flags it picks the next child. A child that is flagged as a leaf goes to a leaf interface. The leaf interface either reports a primitive leaf, which ends that branch, or returns a new cluster root, which becomes the thread's base. A round-robin picker lets one ready thread issue per cycle.

Top module: `bvh_walk_ctrl`

## Requirements
- R1: After reset no fetch, leaf or test request is valid and no thread reports done.
- R2: Record fields: planes 0..5 at bits [6i+5:6i], ownership mask at [41:36], left and right leaf flags at bits 42 and 43, left pointer at [53:44], right pointer at [63:54]. For each plane i with mask bit 1, the left child takes the record plane and the right child takes the parent plane. With mask bit 0 the two sources swap.
- R3: A record that returns for a thread waiting on a fetch produces a test request with the rebuilt child boxes in the same cycle.
- R4: A started thread first fetches its root at the base it was given. Every child fetch address is the cluster base plus the zero-extended child pointer.
- R5: When both children are hit, the nearer child is visited first and the farther one is pushed. A later pop resumes the farther child with its own box and base.
- R6: A visited child whose leaf flag is set goes to the leaf interface at base plus pointer and is never fetched.
- R7: A glue reply replaces the cluster base with the returned root and fetches it, using the glue child's box as the parent box. A primitive-leaf reply pops the stack.
- R8: The stack holds four entries, and a push onto a full stack discards the oldest entry. An empty-stack pop restarts at the root if an entry was ever discarded. Otherwise the thread reports done, and done holds until the next start.
- R9: Ready threads issue in round-robin order from the thread after the last one that issued. A thread never issues in two consecutive cycles.
- R10: At most one of fetch or leaf request is valid in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_vld | input | 1 | Start a thread |
| start_tid | input | 2 | Thread to start |
| start_base | input | 24 | Root cluster base |
| start_box | input | 36 | Root box, six 6-bit planes |
| fch_vld | output | 1 | Node-pair fetch request |
| fch_tid | output | 2 | Thread issuing the fetch |
| fch_addr | output | 24 | Node-pair address |
| rsp_vld | input | 1 | Record returned |
| rsp_tid | input | 2 | Thread owning the record |
| rsp_rec | input | 64 | Node-pair record |
| tst_vld | output | 1 | Box test request |
| tst_tid | output | 2 | Thread of the test |
| tst_box_l | output | 36 | Rebuilt left child box |
| tst_box_r | output | 36 | Rebuilt right child box |
| hit_vld | input | 1 | Test result valid |
| hit_tid | input | 2 | Thread of the result |
| hit_l | input | 1 | Left child hit |
| hit_r | input | 1 | Right child hit |
| near_l | input | 1 | Left child nearer |
| lf_vld | output | 1 | Leaf request |
| lf_tid | output | 2 | Thread of the leaf request |
| lf_addr | output | 24 | Leaf address |
| lr_vld | input | 1 | Leaf reply valid |
| lr_tid | input | 2 | Thread of the reply |
| lr_glue | input | 1 | 1 = glue node, 0 = primitive leaf |
| lr_root | input | 24 | New cluster root on glue |
| done | output | 4 | Per-thread traversal finished |

## Verification
A corrupted per-thread base, pointer or stack entry appears at the ports on the next fetch or leaf request of that thread, as a wrong address. It shows within one cycle of the decision that uses it. A wrong stored box shows in the very next test request, because the rebuilt child boxes are emitted in the same cycle the record arrives. Stack depth faults, such as losing or keeping the wrong entry on overflow, show as a wrong pop order or as a missing or spurious root restart after the last pop.

// File: rtl/bvh_walk_ctrl.sv
`timescale 1ns/1ps
module bvh_walk_ctrl #(
  parameter int NTHR   = 4,
  parameter int ADDR_W = 24,
  parameter int PTR_W  = 10,
  parameter int PL_W   = 6,
  parameter int STK_D  = 4,
  localparam int TID_W = $clog2(NTHR),
  localparam int BOX_W = 6 * PL_W,
  localparam int REC_W = BOX_W + 8 + 2 * PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_vld,
  input  logic [TID_W-1:0]  start_tid,
  input  logic [ADDR_W-1:0] start_base,
  input  logic [BOX_W-1:0]  start_box,
  output logic              fch_vld,
  output logic [TID_W-1:0]  fch_tid,
  output logic [ADDR_W-1:0] fch_addr,
  input  logic              rsp_vld,
  input  logic [TID_W-1:0]  rsp_tid,
  input  logic [REC_W-1:0]  rsp_rec,
  output logic              tst_vld,
  output logic [TID_W-1:0]  tst_tid,
  output logic [BOX_W-1:0]  tst_box_l,
  output logic [BOX_W-1:0]  tst_box_r,
  input  logic              hit_vld,
  input  logic [TID_W-1:0]  hit_tid,
  input  logic              hit_l,
  input  logic              hit_r,
  input  logic              near_l,
  output logic              lf_vld,
  output logic [TID_W-1:0]  lf_tid,
  output logic [ADDR_W-1:0] lf_addr,
  input  logic              lr_vld,
  input  logic [TID_W-1:0]  lr_tid,
  input  logic              lr_glue,
  input  logic [ADDR_W-1:0] lr_root,
  output logic [NTHR-1:0]   done
);
  localparam int IDX_W = $clog2(STK_D);
  localparam int SP_W  = $clog2(STK_D + 1);
  localparam int ENT_W = 1 + BOX_W + PTR_W + ADDR_W;
  localparam int M_LO  = BOX_W;
  localparam int LF_LO = BOX_W + 6;
  localparam int PL_LO = BOX_W + 8;
  localparam int PR_LO = BOX_W + 8 + PTR_W;

  typedef enum logic [2:0] {S_IDLE, S_FW, S_TW, S_LW, S_DONE} st_t;

  st_t               st     [NTHR];
  logic [NTHR-1:0]   pend, drop;
  logic [SP_W-1:0]   sp     [NTHR];
  logic [ADDR_W-1:0] base   [NTHR];
  logic [ADDR_W-1:0] rbase  [NTHR];
  logic [PTR_W-1:0]  ptr    [NTHR];
  logic [PTR_W-1:0]  cptr_l [NTHR];
  logic [PTR_W-1:0]  cptr_r [NTHR];
  logic [BOX_W-1:0]  box    [NTHR];
  logic [BOX_W-1:0]  rbox   [NTHR];
  logic [BOX_W-1:0]  cbox_l [NTHR];
  logic [BOX_W-1:0]  cbox_r [NTHR];
  logic [1:0]        cleaf  [NTHR];
  logic [ENT_W-1:0]  stk    [NTHR][STK_D];
  logic [ENT_W-1:0]  top    [NTHR];
  logic [TID_W-1:0]  rr, pk;
  logic              pk_ok;
  logic [NTHR-1:0]   go_start, go_rsp, go_hit, go_lr, pop_now;

  function automatic logic [2*BOX_W-1:0] split(input logic [REC_W-1:0] rec,
                                               input logic [BOX_W-1:0] par);
    logic [BOX_W-1:0] l, r;
    for (int i = 0; i < 6; i++) begin
      l[i*PL_W +: PL_W] = rec[M_LO+i] ? rec[i*PL_W +: PL_W] : par[i*PL_W +: PL_W];
      r[i*PL_W +: PL_W] = rec[M_LO+i] ? par[i*PL_W +: PL_W] : rec[i*PL_W +: PL_W];
    end
    return {l, r};
  endfunction

  assign {tst_box_l, tst_box_r} = split(rsp_rec, box[rsp_tid]);
  assign tst_vld = rsp_vld && st[rsp_tid] == S_FW;
  assign tst_tid = rsp_tid;

  wire any_hit  = hit_l | hit_r;
  wire both_hit = hit_l & hit_r;
  wire sel_r    = hit_r && (!hit_l || !near_l);
  wire [PTR_W-1:0] v_ptr  = sel_r ? cptr_r[hit_tid] : cptr_l[hit_tid];
  wire [BOX_W-1:0] v_box  = sel_r ? cbox_r[hit_tid] : cbox_l[hit_tid];
  wire             v_leaf = cleaf[hit_tid][sel_r];
  wire [ENT_W-1:0] far_ent = sel_r
    ? {cleaf[hit_tid][0], cbox_l[hit_tid], cptr_l[hit_tid], base[hit_tid]}
    : {cleaf[hit_tid][1], cbox_r[hit_tid], cptr_r[hit_tid], base[hit_tid]};

  always_comb begin
    pk_ok = 1'b0;
    pk    = rr;
    for (int k = 0; k < NTHR; k++)
      if (!pk_ok && pend[rr + TID_W'(k)]) begin
        pk_ok = 1'b1;
        pk    = rr + TID_W'(k);
      end
  end

  wire [ADDR_W-1:0] iss_addr = base[pk] + ADDR_W'(ptr[pk]);
  assign fch_vld  = pk_ok && st[pk] == S_FW;
  assign lf_vld   = pk_ok && st[pk] == S_LW;
  assign fch_tid  = pk;
  assign lf_tid   = pk;
  assign fch_addr = iss_addr;
  assign lf_addr  = iss_addr;

  always_comb
    for (int t = 0; t < NTHR; t++) begin
      go_start[t] = start_vld && start_tid == TID_W'(t);
      go_rsp[t]   = rsp_vld && rsp_tid == TID_W'(t) && st[t] == S_FW && !go_start[t];
      go_hit[t]   = hit_vld && hit_tid == TID_W'(t) && st[t] == S_TW && !go_start[t];
      go_lr[t]    = lr_vld && lr_tid == TID_W'(t) && st[t] == S_LW && !go_start[t];
      pop_now[t]  = (go_hit[t] && !any_hit) || (go_lr[t] && !lr_glue);
      top[t]      = stk[t][IDX_W'(sp[t] - 1'b1)];
      done[t]     = st[t] == S_DONE;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rr   <= '0;
      pend <= '0;
      drop <= '0;
      for (int t = 0; t < NTHR; t++) begin
        st[t] <= S_IDLE;
        sp[t] <= '0;
      end
    end else begin
      if (pk_ok) rr <= pk + TID_W'(1);
      for (int t = 0; t < NTHR; t++) begin
        if (pk_ok && pk == TID_W'(t)) pend[t] <= 1'b0;
        if (go_start[t]) begin
          st[t] <= S_FW; pend[t] <= 1'b1; sp[t] <= '0; drop[t] <= 1'b0;
        end
        if (go_rsp[t]) st[t] <= S_TW;
        if (go_hit[t] && any_hit) begin
          st[t]   <= v_leaf ? S_LW : S_FW;
          pend[t] <= 1'b1;
          if (both_hit) begin
            if (sp[t] == SP_W'(STK_D)) drop[t] <= 1'b1;
            else                       sp[t]   <= sp[t] + 1'b1;
          end
        end
        if (go_lr[t] && lr_glue) begin
          st[t] <= S_FW; pend[t] <= 1'b1;
        end
        if (pop_now[t]) begin
          if (sp[t] != '0) begin
            st[t]   <= top[t][ENT_W-1] ? S_LW : S_FW;
            pend[t] <= 1'b1;
            sp[t]   <= sp[t] - 1'b1;
          end else if (drop[t]) begin
            st[t] <= S_FW; pend[t] <= 1'b1; drop[t] <= 1'b0;
          end else
            st[t] <= S_DONE;
        end
      end
    end

  always_ff @(posedge clk)
    for (int t = 0; t < NTHR; t++) begin
      if (go_start[t]) begin
        base[t] <= start_base; rbase[t] <= start_base;
        box[t]  <= start_box;  rbox[t]  <= start_box;
        ptr[t]  <= '0;
      end
      if (go_rsp[t]) begin
        cbox_l[t] <= tst_box_l;
        cbox_r[t] <= tst_box_r;
        cleaf[t]  <= rsp_rec[LF_LO +: 2];
        cptr_l[t] <= rsp_rec[PL_LO +: PTR_W];
        cptr_r[t] <= rsp_rec[PR_LO +: PTR_W];
      end
      if (go_hit[t] && any_hit) begin
        ptr[t] <= v_ptr;
        box[t] <= v_box;
        if (both_hit) begin
          if (sp[t] == SP_W'(STK_D)) begin
            for (int d = 0; d < STK_D - 1; d++) stk[t][d] <= stk[t][d+1];
            stk[t][STK_D-1] <= far_ent;
          end else
            stk[t][IDX_W'(sp[t])] <= far_ent;
        end
      end
      if (go_lr[t] && lr_glue) begin
        base[t] <= lr_root;
        ptr[t]  <= '0;
      end
      if (pop_now[t]) begin
        if (sp[t] != '0)
          {box[t], ptr[t], base[t]} <= top[t][ENT_W-2:0];
        else if (drop[t]) begin
          base[t] <= rbase[t]; ptr[t] <= '0; box[t] <= rbox[t];
        end
      end
    end
endmodule

// File: rtl/bvh_walk_ctrl_chk.sv
`timescale 1ns/1ps
module bvh_walk_ctrl_chk #(
  parameter int NTHR  = 4,
  parameter int TID_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_vld,
  input logic             fch_vld,
  input logic             lf_vld,
  input logic [TID_W-1:0] fch_tid,
  input logic             rsp_vld,
  input logic             tst_vld,
  input logic [NTHR-1:0]  done
);
  // R10
  one_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fch_vld && lf_vld));

  // R3
  tst_follows_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tst_vld |-> rsp_vld);

  // R9
  no_repeat_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fch_vld || lf_vld) |=> !((fch_vld || lf_vld) && fch_tid == $past(fch_tid)));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_vld |=> (done & $past(done)) == $past(done));
endmodule

bind bvh_walk_ctrl bvh_walk_ctrl_chk #(.NTHR(NTHR), .TID_W(TID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .fch_vld(fch_vld),
  .lf_vld(lf_vld), .fch_tid(fch_tid), .rsp_vld(rsp_vld), .tst_vld(tst_vld),
  .done(done)
);

// File: tb/tb_bvh_walk_ctrl.sv
`timescale 1ns/1ps
module tb_bvh_walk_ctrl;
  logic clk = 0, rst_n = 0;
  logic start_vld = 0, rsp_vld = 0, hit_vld = 0, hit_l = 0, hit_r = 0, near_l = 0;
  logic lr_vld = 0, lr_glue = 0;
  logic [1:0] start_tid = 0, rsp_tid = 0, hit_tid = 0, lr_tid = 0;
  logic [23:0] start_base = 0, lr_root = 0;
  logic [35:0] start_box = 0;
  logic [63:0] rsp_rec = 0;
  logic fch_vld, tst_vld, lf_vld;
  logic [1:0] fch_tid, tst_tid, lf_tid;
  logic [23:0] fch_addr, lf_addr;
  logic [35:0] tst_box_l, tst_box_r;
  logic [3:0] done;

  bvh_walk_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_tid(start_tid),
    .start_base(start_base), .start_box(start_box), .fch_vld(fch_vld),
    .fch_tid(fch_tid), .fch_addr(fch_addr), .rsp_vld(rsp_vld), .rsp_tid(rsp_tid),
    .rsp_rec(rsp_rec), .tst_vld(tst_vld), .tst_tid(tst_tid), .tst_box_l(tst_box_l),
    .tst_box_r(tst_box_r), .hit_vld(hit_vld), .hit_tid(hit_tid), .hit_l(hit_l),
    .hit_r(hit_r), .near_l(near_l), .lf_vld(lf_vld), .lf_tid(lf_tid),
    .lf_addr(lf_addr), .lr_vld(lr_vld), .lr_tid(lr_tid), .lr_glue(lr_glue),
    .lr_root(lr_root), .done(done)
  );

  always #2.5 clk = ~clk;

  int nvec = 0, nerr = 0;

  // mask, record planes, parent box
  localparam logic [77:0] VEC [6] = '{
    {6'b000000, 36'h0123456789, 36'hFEDCBA987},
    {6'b111111, 36'h0123456789, 36'hFEDCBA987},
    {6'b101010, 36'h3C3C3C3C3,  36'hA5A5A5A5A},
    {6'b010101, 36'h3C3C3C3C3,  36'hA5A5A5A5A},
    {6'b100001, 36'hFFFFFFFFF,  36'h000000000},
    {6'b011100, 36'h000000000,  36'hFFFFFFFFF}
  };

  task automatic chk(input bit ok, input string req, input logic [71:0] act,
                     input logic [71:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [71:0] xsplit(input logic [63:0] rec, input logic [35:0] par);
    logic [35:0] l, r;
    for (int i = 0; i < 6; i++) begin
      if (rec[36+i]) begin
        l[6*i +: 6] = rec[6*i +: 6]; r[6*i +: 6] = par[6*i +: 6];
      end else begin
        l[6*i +: 6] = par[6*i +: 6]; r[6*i +: 6] = rec[6*i +: 6];
      end
    end
    return {l, r};
  endfunction

  function automatic logic [63:0] mkrec(input logic [35:0] pl, input logic [5:0] m,
      input logic lfl, input logic lfr, input logic [9:0] pa, input logic [9:0] pb);
    return {pb, pa, lfr, lfl, m, pl};
  endfunction

  task automatic start_t(input logic [1:0] t, input logic [23:0] b, input logic [35:0] bx);
    @(negedge clk);
    start_vld = 1; start_tid = t; start_base = b; start_box = bx;
    @(posedge clk); #0.5 start_vld = 0;
  endtask

  task automatic exp_fetch(input logic [1:0] t, input logic [23:0] a, input string req);
    @(negedge clk); #0.5;
    chk(fch_vld && !lf_vld && fch_tid == t && fch_addr == a, req,
        {44'd0, lf_vld, fch_vld, fch_tid, fch_addr}, {44'd0, 1'b0, 1'b1, t, a});
  endtask

  task automatic exp_leaf(input logic [1:0] t, input logic [23:0] a, input string req);
    @(negedge clk); #0.5;
    chk(lf_vld && !fch_vld && lf_tid == t && lf_addr == a, req,
        {44'd0, fch_vld, lf_vld, lf_tid, lf_addr}, {44'd0, 1'b0, 1'b1, t, a});
  endtask

  task automatic rsp(input logic [1:0] t, input logic [63:0] rec, input logic [35:0] par,
                     input string req);
    @(negedge clk);
    rsp_vld = 1; rsp_tid = t; rsp_rec = rec; #0.5;
    chk(tst_vld && tst_tid == t && {tst_box_l, tst_box_r} == xsplit(rec, par), req,
        {tst_box_l, tst_box_r}, xsplit(rec, par));
    @(posedge clk); #0.5 rsp_vld = 0;
  endtask

  task automatic hit(input logic [1:0] t, input logic l, input logic r, input logic nl);
    @(negedge clk);
    hit_vld = 1; hit_tid = t; hit_l = l; hit_r = r; near_l = nl;
    @(posedge clk); #0.5 hit_vld = 0;
  endtask

  task automatic lres(input logic [1:0] t, input logic g, input logic [23:0] root);
    @(negedge clk);
    lr_vld = 1; lr_tid = t; lr_glue = g; lr_root = root;
    @(posedge clk); #0.5 lr_vld = 0;
  endtask

  task automatic exp_done(input logic [1:0] t, input string req);
    @(negedge clk); #0.5;
    chk(done[t] && !fch_vld && !lf_vld, req, {66'd0, fch_vld, lf_vld, done},
        {66'd0, 2'b00, done | (4'b1 << t)});
  endtask

  localparam logic [35:0] P = 36'h123456789;
  localparam logic [35:0] Q = 36'h5A5A5A5A5;
  logic [63:0] recA, recB, recC, recD, recE;
  logic [35:0] aL, aR, cL, dR;

  initial begin
    #(5.0 * 100000);
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    @(negedge clk); #0.5;
    // R1
    chk(!fch_vld && !lf_vld && !tst_vld && done == 0, "R1",
        {65'd0, fch_vld, lf_vld, tst_vld, done}, 72'd0);

    // decode table: R2 R3 R4, then empty-stack finish (R8)
    for (int v = 0; v < 6; v++) begin
      start_t(2'd0, 24'h000800, VEC[v][35:0]);
      exp_fetch(2'd0, 24'h000800, "R4 root");
      rsp(2'd0, mkrec(VEC[v][71:36], VEC[v][77:72], 1'b0, 1'b0, 10'd1, 10'd2),
          VEC[v][35:0], "R2/R3 decode");
      hit(2'd0, 1'b0, 1'b0, 1'b0);
      exp_done(2'd0, "R8 no drop");
    end

    // directed walk: R5 R6 R7
    recA = mkrec(36'h9ABCDEF01, 6'b101100, 1'b0, 1'b0, 10'd5, 10'd9);
    {aL, aR} = xsplit(recA, P);
    start_t(2'd0, 24'h001000, P);
    exp_fetch(2'd0, 24'h001000, "R4");
    rsp(2'd0, recA, P, "R2");
    hit(2'd0, 1'b1, 1'b1, 1'b0);
    exp_fetch(2'd0, 24'h001009, "R5 near right");
    recB = mkrec(36'h13579BDF2, 6'b010011, 1'b0, 1'b0, 10'd1, 10'd1);
    rsp(2'd0, recB, aR, "R5 near box");
    hit(2'd0, 1'b0, 1'b0, 1'b0);
    exp_fetch(2'd0, 24'h001005, "R5 pop far");
    recC = mkrec(36'h2468ACE03, 6'b000111, 1'b1, 1'b0, 10'd3, 10'd8);
    cL = xsplit(recC, aL) >> 36;
    rsp(2'd0, recC, aL, "R5 far box");
    hit(2'd0, 1'b1, 1'b0, 1'b0);
    exp_leaf(2'd0, 24'h001003, "R6 leaf");
    lres(2'd0, 1'b1, 24'h004000);
    exp_fetch(2'd0, 24'h004000, "R7 glue base");
    recD = mkrec(36'hFEDCBA987, 6'b110010, 1'b1, 1'b0, 10'd2, 10'd6);
    dR = xsplit(recD, cL);
    rsp(2'd0, recD, cL, "R7 glue box");
    hit(2'd0, 1'b1, 1'b1, 1'b1);
    exp_leaf(2'd0, 24'h004002, "R5 near left leaf");
    lres(2'd0, 1'b0, 24'h0);
    exp_fetch(2'd0, 24'h004006, "R7 primitive pop");
    recE = mkrec(36'h111111111, 6'b000000, 1'b0, 1'b0, 10'd0, 10'd0);
    rsp(2'd0, recE, dR, "R7 popped box");
    hit(2'd0, 1'b0, 1'b0, 1'b0);
    exp_done(2'd0, "R8 done");

    // overflow and restart: R8
    start_t(2'd0, 24'h000200, P);
    for (int k = 0; k < 5; k++) begin
      exp_fetch(2'd0, 24'h000200 + 24'(k), "R8 descend");
      rsp(2'd0, mkrec(Q, 6'b111111, 1'b0, 1'b0, 10'(k + 1), 10'(k + 16)),
          (k == 0) ? P : Q, "R8 descend box");
      hit(2'd0, 1'b1, 1'b1, 1'b1);
    end
    exp_fetch(2'd0, 24'h000205, "R8 deepest");
    rsp(2'd0, mkrec(Q, 6'b111111, 1'b0, 1'b0, 10'd0, 10'd0), Q, "R8 deepest box");
    hit(2'd0, 1'b0, 1'b0, 1'b0);
    for (int k = 4; k >= 1; k--) begin
      exp_fetch(2'd0, 24'h000210 + 24'(k), "R8 pop order");
      rsp(2'd0, mkrec(Q, 6'b111111, 1'b0, 1'b0, 10'd0, 10'd0), Q, "R8 pop box");
      hit(2'd0, 1'b0, 1'b0, 1'b0);
    end
    exp_fetch(2'd0, 24'h000200, "R8 restart root");
    rsp(2'd0, mkrec(Q, 6'b111111, 1'b0, 1'b0, 10'd0, 10'd0), P, "R8 restart box");
    hit(2'd0, 1'b0, 1'b0, 1'b0);
    exp_done(2'd0, "R8 after restart");

    // round robin: R9 R10
    start_t(2'd3, 24'h003000, P);
    exp_fetch(2'd3, 24'h003000, "R4");
    rsp(2'd3, mkrec(Q, 6'b001100, 1'b1, 1'b0, 10'd7, 10'd9), P, "R2");
    hit(2'd3, 1'b1, 1'b0, 1'b0);
    exp_leaf(2'd3, 24'h003007, "R6");
    start_t(2'd1, 24'h001100, P);
    exp_fetch(2'd1, 24'h001100, "R4");
    rsp(2'd1, mkrec(Q, 6'b110011, 1'b0, 1'b0, 10'd4, 10'd5), P, "R3");
    @(negedge clk);
    hit_vld = 1; hit_tid = 2'd1; hit_l = 1; hit_r = 0; near_l = 0;
    lr_vld = 1; lr_tid = 2'd3; lr_glue = 1; lr_root = 24'h005000;
    start_vld = 1; start_tid = 2'd2; start_base = 24'h002200; start_box = P;
    @(posedge clk); #0.5;
    hit_vld = 0; lr_vld = 0; start_vld = 0;
    exp_fetch(2'd2, 24'h002200, "R9 first");
    exp_fetch(2'd3, 24'h005000, "R9 second");
    exp_fetch(2'd1, 24'h001104, "R9 third");
    @(negedge clk); #0.5;
    chk(!fch_vld && !lf_vld, "R10 idle", {70'd0, fch_vld, lf_vld}, 72'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule